// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation converter. A start request picks one of thirteen analog inputs, keeps the sample switch closed for a programmed number of clocks, and then resolves the result one bit at a time. The search begins at the most significant bit. For each bit the block drives a trial code to the DAC, waits a programmed per-bit time and reads the comparator. A short settle phase follows the trials. The result is then published, and a one-cycle done pulse marks it.

One timing byte sets both durations. Its upper three bits give the sample count and its lower five bits give the per-bit count. Out-of-range values are raised to the lowest legal value. A mode input selects a 10-bit or an 8-bit conversion. The channel, mode and timing byte are captured when a start is accepted, so the caller may change them while a conversion runs. The multiplexer, sample capacitor, DAC and comparator lie outside this block and appear only as ports.

States:
- `ST_IDLE` and `ST_DONE` accept a start and go to `ST_SAMPLE`.
- `ST_SAMPLE` goes to `ST_TRIAL` when the sample count runs out.
- `ST_TRIAL` loops once per bit and goes to `ST_SETTLE` after the last bit.
- `ST_SETTLE` goes to `ST_DONE` after three cycles.
- `ST_DONE` lasts one cycle. It returns to `ST_IDLE`, or goes to `ST_SAMPLE` if a new start is present.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset these outputs are all zero: `busy_o`, `done_o`, `sample_o`, `result_o`, `dac_o` and `mux_sel_o`.
- R2: A start is accepted in `ST_IDLE` or `ST_DONE`. Once accepted, `sample_o` and `busy_o` rise in the next cycle. `sample_o` stays high for exactly 8·S+2 cycles, where S is timing bits 7:5.
- R3: The trials run from bit 9 down to the lowest bit of the mode. In the first trial cycle `dac_o` is exactly 10'h200. Each trial lasts 2·(C+1) cycles, where C is timing bits 4:0.
- R4: At the last cycle of a trial, the trial bit is cleared if `cmp_below_i` is 1 (input below DAC level) and kept otherwise. The next lower bit is then set. The final code is therefore the largest code that is not above the input.
- R5: `done_o` is high for exactly one cycle, with `busy_o` low. It appears 8·S+2 + 2·B·(C+1) + 3 cycles after the clock edge that accepted the start, where B is 10 or 8.
- R6: `result_o` changes only in the cycle in which `done_o` is high. With `res10_i`=1 it holds the 10-bit code. With `res10_i`=0 it holds the 8 most significant trial bits in bits 7:0, and bits 9:8 are 0.
- R7: `busy_o` stays high from the cycle after an accepted start until `done_o`. A start while busy has no effect: it produces no extra done and does not change the running conversion's timing, channel or result.
- R8: A sample field of 0 is treated as 1. A per-bit field of 0 or 1 is treated as 2.
- R9: `mux_sel_o` shows the channel captured at the start. A channel value above 12 selects channel 12.
- R10: `chan_i`, `res10_i` and `timing_i` are read only at an accepted start. Changes during a conversion do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled each clock |
| chan_i | input | 4 | Requested channel (0..12, larger values clamp to 12) |
| res10_i | input | 1 | 1 = 10-bit conversion, 0 = 8-bit conversion |
| timing_i | input | 8 | Bits 7:5 sample field S, bits 4:0 per-bit field C |
| cmp_below_i | input | 1 | Comparator: 1 when the input is below the DAC level |
| mux_sel_o | output | 4 | Analog multiplexer select |
| sample_o | output | 1 | Sample switch closed |
| dac_o | output | 10 | Trial code driven to the DAC |
| result_o | output | 10 | Last completed conversion result |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every due time is counted from the clock edge that samples the start. The sample switch is open after 8·S+2 cycles, and the first DAC trial code is visible in the following cycle. The done pulse and the new result appear 8·S+2 + 2·B·(C+1) + 3 cycles after the start.

The bench drives inputs on falling edges and keeps a rising-edge counter. When it issues a start, it records the counter value of the edge that will accept it. The monitor samples on falling edges and compares the measured sample width, first trial code and done latency with the values queued for that conversion. Starts issued while busy, and input changes during a conversion, add nothing to the queue. The monitor flags any unexpected done pulse or result change.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_TRIAL,
        ST_SETTLE,
        ST_DONE
    } sar_state_e;

    // fixed tail after the last trial before the result is published
    localparam int SETTLE_CYC = 3;

endpackage

// File: rtl/sar_time_decode.sv
module sar_time_decode #(
    parameter int SF_W  = 3,
    parameter int CF_W  = 5,
    parameter int MIN_S = 1,
    parameter int MIN_C = 2,
    parameter int CNT_W = 8
) (
    input  logic [SF_W+CF_W-1:0] timing_i,
    output logic [CNT_W-1:0]     samp_len_o,
    output logic [CNT_W-1:0]     bit_len_o
);
    localparam int TW = SF_W + CF_W;

    int s_val;
    int c_val;

    always_comb begin
        s_val = int'(timing_i[TW-1 -: SF_W]);
        c_val = int'(timing_i[CF_W-1:0]);
        if (s_val < MIN_S) s_val = MIN_S;   // R8 clamp
        if (c_val < MIN_C) c_val = MIN_C;   // R8 clamp
        samp_len_o = CNT_W'(8 * s_val + 2);
        bit_len_o  = CNT_W'(2 * (c_val + 1));
    end

endmodule

// File: rtl/sar_chan_clamp.sv
module sar_chan_clamp #(
    parameter int NCH  = 13,
    parameter int CH_W = 4
) (
    input  logic [CH_W-1:0] chan_i,
    output logic [CH_W-1:0] chan_o
);
    // R9: anything past the last channel maps onto the last channel
    assign chan_o = (int'(chan_i) > NCH - 1) ? CH_W'(NCH - 1) : chan_i;

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic                       step_i,
    input  logic                       below_i,
    input  logic [$clog2(W+1)-1:0]     lsb_i,
    output logic [W-1:0]               code_o,
    output logic                       last_o
);
    localparam int IDX_W = $clog2(W + 1);

    logic [IDX_W-1:0] idx_q;
    logic [W-1:0]     code_q;
    logic [W-1:0]     code_nxt;

    assign last_o = (idx_q == lsb_i);
    assign code_o = code_q;

    // per bit: resolve the bit under trial, raise the one below it
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign code_nxt[g] = (IDX_W'(g) == idx_q)               ? (code_q[g] & ~below_i) :
                             ((IDX_W'(g + 1) == idx_q) && !last_o) ? 1'b1 :
                                                                   code_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            code_q <= W'(1) << (W - 1);
            idx_q  <= IDX_W'(W - 1);
        end else if (step_i) begin
            code_q <= code_nxt;
            if (!last_o) idx_q <= idx_q - 1'b1;
        end
    end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int ADC_W = 10,
    parameter int LOW_W = 8,
    parameter int NCH   = 13,
    parameter int CH_W  = 4,
    parameter int SF_W  = 3,
    parameter int CF_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CH_W-1:0]      chan_i,
    input  logic                 res10_i,
    input  logic [SF_W+CF_W-1:0] timing_i,
    input  logic                 cmp_below_i,
    output logic [CH_W-1:0]      mux_sel_o,
    output logic                 sample_o,
    output logic [ADC_W-1:0]     dac_o,
    output logic [ADC_W-1:0]     result_o,
    output logic                 busy_o,
    output logic                 done_o
);
    import sar_seq_pkg::*;

    localparam int SAMP_MAX = 8 * (2**SF_W - 1) + 2;
    localparam int BIT_MAX  = 2 * (2**CF_W);
    localparam int LEN_MAX  = (SAMP_MAX > BIT_MAX) ? SAMP_MAX : BIT_MAX;
    localparam int CNT_W    = $clog2(LEN_MAX + 1);
    localparam int IDX_W    = $clog2(ADC_W + 1);
    localparam int DROP     = ADC_W - LOW_W;

    sar_state_e state_q, state_d;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bit_len_q;
    logic [CH_W-1:0]  chan_q;
    logic             res10_q;
    logic [ADC_W-1:0] result_q;

    logic [CNT_W-1:0] samp_len_w;
    logic [CNT_W-1:0] bit_len_w;
    logic [CH_W-1:0]  chan_w;
    logic [ADC_W-1:0] code_w;
    logic             last_w;
    logic [IDX_W-1:0] lsb_w;

    logic accept_w;
    logic cnt_zero_w;
    logic trial_load_w;
    logic trial_step_w;

    sar_time_decode #(
        .SF_W (SF_W),
        .CF_W (CF_W),
        .MIN_S(1),
        .MIN_C(2),
        .CNT_W(CNT_W)
    ) u_time (
        .timing_i  (timing_i),
        .samp_len_o(samp_len_w),
        .bit_len_o (bit_len_w)
    );

    sar_chan_clamp #(
        .NCH (NCH),
        .CH_W(CH_W)
    ) u_chan (
        .chan_i(chan_i),
        .chan_o(chan_w)
    );

    sar_trial_reg #(
        .W(ADC_W)
    ) u_trial (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (trial_load_w),
        .step_i (trial_step_w),
        .below_i(cmp_below_i),
        .lsb_i  (lsb_w),
        .code_o (code_w),
        .last_o (last_w)
    );

    assign lsb_w        = res10_q ? '0 : IDX_W'(DROP);
    assign cnt_zero_w   = (cnt_q == '0);
    assign accept_w     = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    assign trial_load_w = (state_q == ST_SAMPLE) && cnt_zero_w;
    assign trial_step_w = (state_q == ST_TRIAL) && cnt_zero_w;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept_w) state_d = ST_SAMPLE;
            ST_SAMPLE: if (cnt_zero_w) state_d = ST_TRIAL;
            ST_TRIAL:  if (cnt_zero_w && last_w) state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_zero_w) state_d = ST_DONE;
            ST_DONE:   state_d = accept_w ? ST_SAMPLE : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            bit_len_q <= '0;
            chan_q    <= '0;
            res10_q   <= 1'b0;
            result_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept_w) begin
                // R10: inputs captured only here
                cnt_q     <= samp_len_w - 1'b1;
                bit_len_q <= bit_len_w;
                chan_q    <= chan_w;
                res10_q   <= res10_i;
            end else begin
                unique case (state_q)
                    ST_SAMPLE: cnt_q <= cnt_zero_w ? bit_len_q - 1'b1 : cnt_q - 1'b1;
                    ST_TRIAL: begin
                        if (!cnt_zero_w)  cnt_q <= cnt_q - 1'b1;
                        else if (last_w)  cnt_q <= CNT_W'(SETTLE_CYC - 1);
                        else              cnt_q <= bit_len_q - 1'b1;
                    end
                    ST_SETTLE: begin
                        if (!cnt_zero_w) begin
                            cnt_q <= cnt_q - 1'b1;
                        end else begin
                            result_q <= res10_q ? code_w : (code_w >> DROP);
                        end
                    end
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        busy_o    = 1'b0;
        sample_o  = 1'b0;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SAMPLE: begin busy_o = 1'b1; sample_o = 1'b1; end
            ST_TRIAL:  busy_o = 1'b1;
            ST_SETTLE: busy_o = 1'b1;
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
        mux_sel_o = chan_q;
        dac_o     = code_w;
        result_o  = result_q;
    end

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int ADC_W = 10,
    parameter int NCH   = 13,
    parameter int CH_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CH_W-1:0]  mux_sel_o,
    input logic             sample_o,
    input logic [ADC_W-1:0] result_o,
    input logic             busy_o,
    input logic             done_o
);

    a_r2_sample_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> busy_o);

    a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r6_result_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r9_mux_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel_o <= CH_W'(NCH - 1));

    a_r10_mux_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
    .ADC_W(ADC_W),
    .NCH  (NCH),
    .CH_W (CH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mux_sel_o(mux_sel_o),
    .sample_o (sample_o),
    .result_o (result_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;

    typedef struct {
        int n0;
        int lat;
        int samp;
        int ch;
        int res;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] chan_i = '0;
    logic       res10_i = 1'b1;
    logic [7:0] timing_i = '0;
    logic       cmp_below_i;
    logic [3:0] mux_sel_o;
    logic       sample_o;
    logic [9:0] dac_o;
    logic [9:0] result_o;
    logic       busy_o;
    logic       done_o;

    logic [9:0] vin = '0;
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    int n_issued = 0;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // comparator model: input below the DAC trial level
    assign cmp_below_i = (vin < dac_o);

    sar_conv_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .res10_i(res10_i), .timing_i(timing_i), .cmp_below_i(cmp_below_i),
        .mux_sel_o(mux_sel_o), .sample_o(sample_o), .dac_o(dac_o),
        .result_o(result_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // driver: issue one conversion and queue its expected outcome
    task automatic run_conv(input logic [7:0] t, input logic [3:0] ch, input bit m10,
                            input logic [9:0] v, input bit poke, input bit at_done);
        exp_t e;
        int s, c, b;
        if (at_done) begin
            do @(negedge clk); while (!done_o);
        end else begin
            @(negedge clk);
            while (busy_o) @(negedge clk);
        end
        s = (t[7:5] == 0) ? 1 : int'(t[7:5]);
        c = (t[4:0] < 2) ? 2 : int'(t[4:0]);
        b = m10 ? 10 : 8;
        e.n0   = cyc + 1;
        e.samp = 8 * s + 2;
        e.lat  = e.samp + 2 * b * (c + 1) + 3;
        e.ch   = (ch > 12) ? 12 : int'(ch);
        e.res  = m10 ? int'(v) : int'(v >> 2);
        q.push_back(e);
        n_issued++;
        vin = v; timing_i = t; chan_i = ch; res10_i = m10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R7/R10: start and input changes while busy must have no effect
            repeat (15) @(negedge clk);
            start_i = 1'b1; timing_i = ~t; chan_i = ch ^ 4'h5; res10_i = ~m10;
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    // monitor / scoreboard
    int  samp_cnt = 0;
    int  ch_seen = -1;
    int  dac_first = -1;
    bit  prev_samp = 1'b0;
    bit  res_moved = 1'b0;
    logic [9:0] last_res = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_o) begin
                samp_cnt++;
                ch_seen = int'(mux_sel_o);
            end
            if (prev_samp && !sample_o && busy_o) dac_first = int'(dac_o);
            if (busy_o && (result_o != last_res)) res_moved = 1'b1;
            prev_samp = sample_o;
            if (done_o) begin
                exp_t e;
                n_done++;
                if (q.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", n_done, n_issued);
                end else begin
                    e = q.pop_front();
                    chk(cyc - e.n0 == e.lat, "R5/R3/R8 done latency", cyc - e.n0, e.lat);
                    chk(samp_cnt == e.samp, "R2/R8 sample width", samp_cnt, e.samp);
                    chk(ch_seen == e.ch, "R9/R2 channel select", ch_seen, e.ch);
                    chk(dac_first == 10'h200, "R3 first trial code", dac_first, 10'h200);
                    chk(int'(result_o) == e.res, "R4/R6 result value", int'(result_o), e.res);
                    chk(!busy_o, "R5 busy low at done", int'(busy_o), 0);
                    chk(!res_moved, "R6 result held during conversion", int'(res_moved), 0);
                end
                last_res  = result_o;
                samp_cnt  = 0;
                ch_seen   = -1;
                dac_first = -1;
                res_moved = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 200000);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!busy_o && !done_o && !sample_o, "R1 control outputs at reset",
            int'({busy_o, done_o, sample_o}), 0);
        chk(result_o == 0 && dac_o == 0 && mux_sel_o == 0, "R1 data outputs at reset",
            int'(result_o) + int'(dac_o) + int'(mux_sel_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R1 idle after reset release", int'(busy_o), 0);

        run_conv(8'h22, 4'd3,  1'b1, 10'h2AB, 1'b0, 1'b0); // S=1 C=2 10-bit
        run_conv(8'hFF, 4'd7,  1'b0, 10'h3FF, 1'b0, 1'b0); // S=7 C=31 8-bit full scale
        run_conv(8'h00, 4'd12, 1'b1, 10'h000, 1'b0, 1'b0); // R8 clamp both fields
        run_conv(8'h41, 4'd15, 1'b0, 10'h201, 1'b0, 1'b0); // R8 C=1, R9 ch 15 -> 12
        run_conv(8'h63, 4'd0,  1'b1, 10'h200, 1'b1, 1'b0); // R7/R10 poke while busy
        run_conv(8'h24, 4'd9,  1'b1, 10'h1FF, 1'b0, 1'b1); // R2 start accepted at done
        run_conv(8'h45, 4'd13, 1'b0, 10'h155, 1'b1, 1'b0); // R7/R10 8-bit poke
        run_conv(8'h22, 4'd1,  1'b1, 10'h3FF, 1'b0, 1'b0); // R4 all ones

        do @(negedge clk); while (q.size() != 0);
        repeat (20) @(negedge clk);
        chk(n_done == n_issued, "R7 done count", n_done, n_issued);
        chk(!busy_o, "R7 idle at end", int'(busy_o), 0);
        finish_run();
    end

endmodule